// File: doc/BRIEF.md
# Multi-channel ADC scan sequencer

This block is the digital control in front of a four-input multiplexed 8-bit converter. Software writes a control word that picks a mode, a channel or a channel mask, and a run bit. The sequencer then sends one start pulse to the converter for each channel it visits, with the channel index alongside. It waits for the converter's done strobe and stores the sample in the result register of that channel. When a pass ends it raises a sticky completion flag. That flag drives the interrupt line only while the interrupt enable is set.

There are four modes. The fixed single and fixed continuous modes convert one channel, once or over and over. The scan single and scan continuous modes walk any subset of the channels in ascending order. In continuous scan, after the highest selected channel the sequence wraps back to the lowest one. A separate DAC path writes the channel-3 result register directly, and that value appears on a DAC output when DAC mode is on.

Top module: `adc_scan_seq`

## Requirements
- R1: Each conversion begins with convStart high for exactly one cycle, with the channel index on convCh. The sample on convData is stored when convDone is high, and it appears on the channel's 8-bit slot of results (bits 8c+7..8c) the next cycle.
- R2: A result slot changes only when a conversion of that channel completes, or when the DAC writes slot 3. The other slots keep their values.
- R3: Mode 2'b00 (bit 1 = scan, bit 0 = continuous) is fixed single. It converts channel ctrlFixCh once, sets irqFlag, clears the run bit and returns to idle (busy low).
- R4: Mode 2'b01 is fixed continuous. It converts ctrlFixCh repeatedly and sets irqFlag at the end of every conversion.
- R5: In the scan modes (2'b10, 2'b11), the channels whose ctrlMask bit is set are converted in ascending index order. Each next start pulse comes in the cycle right after the previous convDone, so no cycle is spent on an unselected channel.
- R6: In the scan modes, irqFlag rises only when the highest selected channel of a pass completes, not after earlier channels.
- R7: Mode 2'b11 is scan continuous. After the highest selected channel it restarts at the lowest selected channel, with the same one-cycle spacing.
- R8: Starting a scan with ctrlMask equal to zero performs no conversion, leaves busy low and does not set irqFlag.
- R9: irq is high exactly when irqFlag is set and the interrupt enable (loaded from ctrlIrqEn on every ctrlWr) is set.
- R10: irqFlag stays set until irqClr is pulsed. If a pass ends in the same cycle as the clear, the set wins.
- R11: A ctrlWr with ctrlRun low stops sequencing after the conversion in progress. That result is still stored. If the pass was incomplete, irqFlag is not set, and no further start pulse follows.
- R12: dacWr loads dacData into the channel-3 slot. The next cycle, dacOut shows that slot when dacEn is high, and dacOut is zero when dacEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWr | input | 1 | Control word write strobe |
| ctrlMode | input | 2 | Mode: bit 1 scan, bit 0 continuous |
| ctrlFixCh | input | 2 | Channel used in the fixed modes |
| ctrlMask | input | 4 | Channel mask used in the scan modes |
| ctrlRun | input | 1 | Run bit: 1 starts a sequence, 0 stops it |
| ctrlIrqEn | input | 1 | Interrupt enable |
| irqClr | input | 1 | Clears the completion flag |
| dacEn | input | 1 | DAC mode enable |
| dacWr | input | 1 | Write strobe for the channel-3 data register |
| dacData | input | 8 | Value written to the channel-3 data register |
| convStart | output | 1 | One-cycle start request to the converter |
| convCh | output | 2 | Channel to convert |
| convDone | input | 1 | Conversion complete strobe |
| convData | input | 8 | Converted sample |
| results | output | 32 | Result registers, channel c in bits 8c+7..8c |
| busy | output | 1 | Sequence in progress |
| irqFlag | output | 1 | Sticky completion flag |
| irq | output | 1 | Gated interrupt request |
| dacOut | output | 8 | DAC output value |

## Verification
A ctrlWr that starts a run produces convStart in the cycle that follows. A convDone shows up as a new result slot, a rising irqFlag and, in mid-pass, the next convStart, all one cycle later. A dacWr reaches dacOut one cycle later. The bench's converter model samples convStart and drives convDone at falling edges, a fixed latency after each start. It logs the cycle of each start, so it can check the spacing of LAT+1 cycles between starts and the flag value at every start. Outputs are compared only at falling edges after busy has dropped, or one full cycle after a write strobe, so every register on the path has been updated.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADC_CHANS = 4;
  localparam int ADC_DW    = 8;
  localparam int ADC_CH_W  = $clog2(ADC_CHANS);

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic                wrRes;
    logic [ADC_CH_W-1:0] resIdx;
    logic                setFlag;
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH  = ADC_CHANS,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctrlWr,
  input  logic [1:0]      ctrlMode,
  input  logic [CHW-1:0]  ctrlFixCh,
  input  logic [NCH-1:0]  ctrlMask,
  input  logic            ctrlRun,
  input  logic            convDone,
  output logic            convStart,
  output logic [CHW-1:0]  convCh,
  output logic            busy,
  output seqStrobe_t      strobe
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  state_t         state;
  logic           runQ;
  logic [1:0]     modeQ;
  logic [NCH-1:0] maskQ;
  logic [CHW-1:0] curCh;

  function automatic logic [CHW-1:0] lowestSel(input logic [NCH-1:0] m);
    logic [CHW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) if (m[i]) r = CHW'(i);
    return r;
  endfunction

  function automatic logic anyAbove(input logic [NCH-1:0] m, input logic [CHW-1:0] c);
    logic f;
    f = 1'b0;
    for (int i = 0; i < NCH; i++) if (m[i] && (i > int'(c))) f = 1'b1;
    return f;
  endfunction

  function automatic logic [CHW-1:0] nextSel(input logic [NCH-1:0] m, input logic [CHW-1:0] c);
    logic [CHW-1:0] r;
    r = c;
    for (int i = NCH - 1; i >= 0; i--) if (m[i] && (i > int'(c))) r = CHW'(i);
    return r;
  endfunction

  logic [NCH-1:0] startMask;
  logic           lastOfPass;
  logic           runNow;

  always_comb begin
    startMask  = ctrlMode[1] ? ctrlMask : (NCH'(1) << ctrlFixCh);
    lastOfPass = !anyAbove(maskQ, curCh);
    runNow     = ctrlWr ? ctrlRun : runQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      runQ  <= 1'b0;
      modeQ <= '0;
      maskQ <= '0;
      curCh <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (ctrlWr) begin
            modeQ <= ctrlMode;
            maskQ <= startMask;
            runQ  <= ctrlRun && (startMask != '0);
            if (ctrlRun && (startMask != '0)) begin
              curCh <= lowestSel(startMask);
              state <= S_ISSUE;
            end
          end
        end
        S_ISSUE: begin
          if (ctrlWr) runQ <= ctrlRun;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (ctrlWr) runQ <= ctrlRun;
          if (convDone) begin
            if (!runNow) begin
              state <= S_IDLE;
            end else if (!lastOfPass) begin
              curCh <= nextSel(maskQ, curCh);
              state <= S_ISSUE;
            end else if (modeQ[0]) begin
              curCh <= lowestSel(maskQ);
              state <= S_ISSUE;
            end else begin
              runQ  <= 1'b0;
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    convStart      = (state == S_ISSUE);
    convCh         = curCh;
    busy           = (state != S_IDLE);
    strobe.wrRes   = (state == S_WAIT) && convDone;
    strobe.resIdx  = curCh;
    strobe.setFlag = (state == S_WAIT) && convDone && lastOfPass;
  end
endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int NCH = ADC_CHANS,
  parameter int DW  = ADC_DW
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      strobe,
  input  logic [DW-1:0]   convData,
  input  logic            ctrlWr,
  input  logic            ctrlIrqEn,
  input  logic            irqClr,
  input  logic            dacEn,
  input  logic            dacWr,
  input  logic [DW-1:0]   dacData,
  output logic [NCH*DW-1:0] results,
  output logic            irqFlag,
  output logic            irq,
  output logic [DW-1:0]   dacOut
);
  localparam int DAC_CH = NCH - 1;

  logic [DW-1:0] resQ [NCH];
  logic          irqEnQ;

  for (genvar c = 0; c < NCH; c++) begin : g_res
    if (c == DAC_CH) begin : g_dac
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) resQ[c] <= '0;
        else if (dacWr) resQ[c] <= dacData;
        else if (strobe.wrRes && (int'(strobe.resIdx) == c)) resQ[c] <= convData;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) resQ[c] <= '0;
        else if (strobe.wrRes && (int'(strobe.resIdx) == c)) resQ[c] <= convData;
      end
    end
    assign results[c*DW +: DW] = resQ[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
      irqEnQ  <= 1'b0;
    end else begin
      if (ctrlWr) irqEnQ <= ctrlIrqEn;
      if (strobe.setFlag) irqFlag <= 1'b1;
      else if (irqClr) irqFlag <= 1'b0;
    end
  end

  always_comb begin
    irq    = irqFlag && irqEnQ;
    dacOut = dacEn ? resQ[DAC_CH] : '0;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH  = ADC_CHANS,
  parameter int DW   = ADC_DW,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [1:0]        ctrlMode,
  input  logic [CHW-1:0]    ctrlFixCh,
  input  logic [NCH-1:0]    ctrlMask,
  input  logic              ctrlRun,
  input  logic              ctrlIrqEn,
  input  logic              irqClr,
  input  logic              dacEn,
  input  logic              dacWr,
  input  logic [DW-1:0]     dacData,
  output logic              convStart,
  output logic [CHW-1:0]    convCh,
  input  logic              convDone,
  input  logic [DW-1:0]     convData,
  output logic [NCH*DW-1:0] results,
  output logic              busy,
  output logic              irqFlag,
  output logic              irq,
  output logic [DW-1:0]     dacOut
);
  seqStrobe_t strobe;

  adc_seq_ctrl #(.NCH(NCH)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlMode(ctrlMode),
    .ctrlFixCh(ctrlFixCh), .ctrlMask(ctrlMask), .ctrlRun(ctrlRun),
    .convDone(convDone), .convStart(convStart), .convCh(convCh),
    .busy(busy), .strobe(strobe)
  );

  adc_seq_dpath #(.NCH(NCH), .DW(DW)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .convData(convData),
    .ctrlWr(ctrlWr), .ctrlIrqEn(ctrlIrqEn), .irqClr(irqClr),
    .dacEn(dacEn), .dacWr(dacWr), .dacData(dacData),
    .results(results), .irqFlag(irqFlag), .irq(irq), .dacOut(dacOut)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWr,
  input logic [1:0]        ctrlMode,
  input logic [NCH-1:0]    ctrlMask,
  input logic              ctrlRun,
  input logic              irqClr,
  input logic              dacEn,
  input logic              dacWr,
  input logic [DW-1:0]     dacData,
  input logic              convStart,
  input logic              convDone,
  input logic [NCH*DW-1:0] results,
  input logic              busy,
  input logic              irqFlag,
  input logic [DW-1:0]     dacOut
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R1

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!convDone && !dacWr) |=> $stable(results)); // R2

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(convDone)); // R6

  AST_EMPTY_MASK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlRun && ctrlMode[1] && (ctrlMask == '0) && !busy) |=> !busy); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag); // R10

  AST_DAC_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (dacWr && dacEn) |=> (dacOut == $past(dacData))); // R12
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlMode(ctrlMode),
  .ctrlMask(ctrlMask), .ctrlRun(ctrlRun), .irqClr(irqClr), .dacEn(dacEn),
  .dacWr(dacWr), .dacData(dacData), .convStart(convStart),
  .convDone(convDone), .results(results), .busy(busy),
  .irqFlag(irqFlag), .dacOut(dacOut)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb_top;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWr = 1'b0;
  logic [1:0] ctrlMode = '0;
  logic [1:0] ctrlFixCh = '0;
  logic [3:0] ctrlMask = '0;
  logic       ctrlRun = 1'b0;
  logic       ctrlIrqEn = 1'b0;
  logic       irqClr = 1'b0;
  logic       dacEn = 1'b0;
  logic       dacWr = 1'b0;
  logic [7:0] dacData = '0;
  logic       convStart;
  logic [1:0] convCh;
  logic       convDone = 1'b0;
  logic [7:0] convData = '0;
  logic [31:0] results;
  logic       busy, irqFlag, irq;
  logic [7:0] dacOut;

  always #2.5 clk = ~clk;

  adc_scan_seq dut_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlMode(ctrlMode),
    .ctrlFixCh(ctrlFixCh), .ctrlMask(ctrlMask), .ctrlRun(ctrlRun),
    .ctrlIrqEn(ctrlIrqEn), .irqClr(irqClr), .dacEn(dacEn), .dacWr(dacWr),
    .dacData(dacData), .convStart(convStart), .convCh(convCh),
    .convDone(convDone), .convData(convData), .results(results),
    .busy(busy), .irqFlag(irqFlag), .irq(irq), .dacOut(dacOut)
  );

  int nTests = 0;
  int nFail  = 0;

  // Converter model log
  int         cyc = 0;
  int         logN = 0;
  int         totalConv = 0;
  logic [1:0] logCh   [64];
  int         logCyc  [64];
  logic       logFlag [64];
  logic [7:0] expRes  [4];

  function automatic logic [7:0] sampleOf(input logic [1:0] ch, input int k);
    return 8'((int'(ch) * 64) + (k * 7) + 3);
  endfunction

  initial begin
    int pend;
    logic [1:0] ch;
    pend = 0;
    ch = '0;
    forever begin
      @(negedge clk);
      cyc++;
      convDone = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          convDone = 1'b1;
          convData = sampleOf(ch, totalConv);
          expRes[ch] = convData;
          totalConv++;
        end
      end else if (convStart) begin
        ch = convCh;
        if (logN < 64) begin
          logCh[logN]   = convCh;
          logCyc[logN]  = cyc;
          logFlag[logN] = irqFlag;
        end
        logN++;
        pend = LAT;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  task automatic writeCtrl(input logic [1:0] m, input logic [1:0] f,
                           input logic [3:0] k, input logic run, input logic ie);
    @(negedge clk);
    ctrlWr = 1'b1; ctrlMode = m; ctrlFixCh = f; ctrlMask = k;
    ctrlRun = run; ctrlIrqEn = ie;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic checkResults(input string req);
    for (int c = 0; c < 4; c++) chk(req, 32'(results[c*8 +: 8]), 32'(expRes[c]));
  endtask

  // {mode[1:0], fixCh[1:0], mask[3:0], count[2:0], seq[7:0]} with seq[1:0] first
  localparam logic [18:0] VEC [7] = '{
    {2'b00, 2'd2, 4'b0000, 3'd1, 8'h02},
    {2'b00, 2'd0, 4'b1111, 3'd1, 8'h00},
    {2'b10, 2'd0, 4'b1111, 3'd4, 8'hE4},
    {2'b10, 2'd3, 4'b1010, 3'd2, 8'h0D},
    {2'b10, 2'd1, 4'b0101, 3'd2, 8'h08},
    {2'b10, 2'd0, 4'b1000, 3'd1, 8'h03},
    {2'b10, 2'd0, 4'b0110, 3'd2, 8'h09}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int c = 0; c < 4; c++) expRes[c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R1 reset convStart", 32'(convStart), 0);
    chk("R3 reset busy", 32'(busy), 0);
    chk("R10 reset irqFlag", 32'(irqFlag), 0);
    chk("R9 reset irq", 32'(irq), 0);
    chk("R2 reset results", results, 0);
    chk("R12 reset dacOut", 32'(dacOut), 0);

    // Table of single-pass runs
    for (int v = 0; v < 7; v++) begin
      logic [1:0] m; logic [1:0] f; logic [3:0] k; int n; logic [7:0] s;
      {m, f, k, n, s} = {VEC[v][18:17], VEC[v][16:15], VEC[v][14:11], 32'(VEC[v][10:8]), VEC[v][7:0]};
      clearFlag();
      logN = 0;
      writeCtrl(m, f, k, 1'b1, 1'b1);
      waitIdle();
      chk("R5 conversion count", 32'(logN), 32'(n));
      for (int i = 0; i < n; i++) begin
        chk("R5 channel order", 32'(logCh[i]), 32'(s[2*i +: 2]));
        if (i < n - 1) chk("R6 flag low mid-pass", 32'(logFlag[i]), 0);
        if (i > 0) chk("R5 start spacing", 32'(logCyc[i] - logCyc[i-1]), LAT + 1);
      end
      checkResults("R1 R2 stored results");
      chk("R3 R6 flag after pass", 32'(irqFlag), 1);
      chk("R9 irq enabled", 32'(irq), 1);
      chk("R3 idle after single pass", 32'(busy), 0);
    end

    // R8: empty mask
    clearFlag();
    logN = 0;
    writeCtrl(2'b10, 2'd0, 4'b0000, 1'b1, 1'b1);
    repeat (LAT + 3) @(negedge clk);
    chk("R8 no conversions", 32'(logN), 0);
    chk("R8 busy low", 32'(busy), 0);
    chk("R8 flag low", 32'(irqFlag), 0);

    // R9/R10: gating and stickiness
    logN = 0;
    writeCtrl(2'b00, 2'd1, 4'b0000, 1'b1, 1'b0);
    waitIdle();
    chk("R9 flag set", 32'(irqFlag), 1);
    chk("R9 irq masked", 32'(irq), 0);
    repeat (5) @(negedge clk);
    chk("R10 flag sticky", 32'(irqFlag), 1);
    writeCtrl(2'b00, 2'd1, 4'b0000, 1'b0, 1'b1);
    chk("R9 irq after enable", 32'(irq), 1);
    clearFlag();
    chk("R10 flag cleared", 32'(irqFlag), 0);
    chk("R9 irq cleared", 32'(irq), 0);

    // R4 + R11: fixed continuous, stop during third conversion
    logN = 0;
    writeCtrl(2'b01, 2'd1, 4'b0000, 1'b1, 1'b1);
    while (logN < 3) @(negedge clk);
    writeCtrl(2'b01, 2'd1, 4'b0000, 1'b0, 1'b1);
    waitIdle();
    repeat (LAT + 3) @(negedge clk);
    chk("R11 stop after current", 32'(logN), 3);
    for (int i = 0; i < 3; i++) chk("R4 same channel", 32'(logCh[i]), 1);
    chk("R4 flag per conversion", 32'(logFlag[1]), 1);
    checkResults("R11 last result stored");

    // R7: scan continuous wrap, mask 1010
    clearFlag();
    logN = 0;
    writeCtrl(2'b11, 2'd0, 4'b1010, 1'b1, 1'b1);
    while (logN < 5) @(negedge clk);
    writeCtrl(2'b11, 2'd0, 4'b1010, 1'b0, 1'b1);
    waitIdle();
    chk("R7 conversion count", 32'(logN), 5);
    for (int i = 0; i < 5; i++) begin
      chk("R7 wrap order", 32'(logCh[i]), (i % 2 == 0) ? 1 : 3);
      if (i > 0) chk("R7 wrap spacing", 32'(logCyc[i] - logCyc[i-1]), LAT + 1);
    end
    chk("R6 flag low before first pass end", 32'(logFlag[1]), 0);
    chk("R7 flag set by pass", 32'(logFlag[2]), 1);
    checkResults("R7 results");

    // R11: mid-pass stop leaves flag low
    clearFlag();
    logN = 0;
    writeCtrl(2'b10, 2'd0, 4'b1111, 1'b1, 1'b1);
    while (logN < 2) @(negedge clk);
    writeCtrl(2'b10, 2'd0, 4'b1111, 1'b0, 1'b1);
    waitIdle();
    repeat (LAT + 3) @(negedge clk);
    chk("R11 mid-pass stop count", 32'(logN), 2);
    chk("R11 no flag on partial pass", 32'(irqFlag), 0);
    checkResults("R11 partial results");

    // R12: DAC path
    @(negedge clk); dacEn = 1'b0; dacWr = 1'b1; dacData = 8'h5A;
    @(negedge clk); dacWr = 1'b0;
    expRes[3] = 8'h5A;
    chk("R12 dacOut zero when off", 32'(dacOut), 0);
    checkResults("R12 R2 slot 3 written");
    @(negedge clk); dacEn = 1'b1;
    #1 chk("R12 dacOut shows slot 3", 32'(dacOut), 32'h5A);
    @(negedge clk); dacWr = 1'b1; dacData = 8'hC3;
    @(negedge clk); dacWr = 1'b0;
    chk("R12 dacOut next cycle", 32'(dacOut), 32'hC3);

    finishRun();
  end
endmodule